// File: doc/BRIEF.md
# I2C Passive Bus Observer

This block listens to a two-wire I2C bus (up to 100 kHz) without ever driving it. It brings SCL and SDA into the system clock domain, removes short glitches, and recognises START, repeated START and STOP conditions. It assembles each 8-bit byte, MSB first, together with its ninth acknowledge bit, and marks the first byte after any START or repeated START as an address byte.

Each transaction is held in a small capture store until its closing STOP arrives. The store holds two 8-byte pages. The block then decides whether to keep the transaction. When filtering is on, only transactions whose opening address matches a chosen 7-bit value are kept. A kept transaction is replayed on a token stream: data bytes interleaved with START, repeated-START, ACK, NACK and STOP markers, in bus order. The STOP token carries the value of a free-running millisecond counter latched when the STOP was seen.

An abort input returns the observer to idle at any moment. It throws away the transaction in progress and any replay that has not been emitted yet.

Top module: `i2c_bus_observer`

## Requirements
- R1: After reset, `tok_valid`, `bus_busy` and `cap_overflow` are all 0.
- R2: `bus_busy` rises after a START (SDA falling while SCL is high) and falls after a STOP (SDA rising while SCL is high).
- R3: Bytes are assembled MSB first, sampled on the filtered rising SCL edge. Each byte token is followed by an acknowledge token: `tok_kind` 4 (ACK) when SDA was low on the ninth clock, or 5 (NACK) when it was high.
- R4: A kept transaction is emitted as kind 0 (START), then its bytes, then kind 6 (STOP). The first byte after a START has kind 2 (address) and later bytes have kind 3 (data). `tok_byte` holds the byte value.
- R5: A START seen while the bus is busy is emitted as kind 1 (repeated START), and the byte that follows it again has kind 2.
- R6: With `filt_en`=1, a transaction whose first address byte has bits [7:1] equal to `filt_addr` is emitted in full, including bytes after any repeated START.
- R7: With `filt_en`=1, a transaction whose first address byte does not match produces no tokens at all.
- R8: With `filt_en`=0, every transaction is emitted whatever its address.
- R9: The STOP token carries on `tok_stamp` the millisecond count, which advances once every `CLK_PER_MS` clocks, at the time the STOP was detected. Stamps of later transactions are not smaller, and they reflect the idle time between transactions.
- R10: The capture store holds 2×`PAGE_BYTES` bytes. A transaction with one more byte raises `cap_overflow` and emits nothing; `cap_overflow` stays high until the next START. A transaction that exactly fills the store is emitted normally.
- R11: A one-cycle `abort` pulse clears `bus_busy` on the next cycle and discards the partial transaction: its STOP emits nothing. The next full transaction is captured normally.
- R12: Holding SCL low for a long stretch inside a byte does not change the captured byte.
- R13: An SCL pulse shorter than `FILT_LEN` clocks is ignored and adds no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| abort | input | 1 | Return to idle and drop the pending transaction |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| filt_en | input | 1 | Enable address filtering |
| filt_addr | input | 7 | 7-bit address to keep when filtering |
| tok_valid | output | 1 | Token present this cycle |
| tok_kind | output | 3 | Token kind: 0 START, 1 repeated START, 2 address, 3 data, 4 ACK, 5 NACK, 6 STOP |
| tok_byte | output | 8 | Byte value for kinds 2 and 3, else 0 |
| tok_stamp | output | TS_W | Millisecond stamp on STOP tokens, else 0 |
| bus_busy | output | 1 | Bus is between a START and a STOP |
| cap_overflow | output | 1 | Current transaction exceeded the capture store |

## Verification
The bench drives a combined transaction so that a design which treats the byte after a repeated START as data, or emits the repeated START as a plain START, shows up in the stream. It sends one byte more than the store holds, and also exactly as many as it holds, so an off-by-one capacity check either drops a legal transaction or emits a truncated one. Abort mid-byte, clock stretching and a sub-filter SCL spike target designs that keep stale bits, count spurious edges or answer a STOP after abort. Filter mismatch and separation in time target designs that leak rejected traffic or stamp from the wrong moment.

// File: rtl/obs_pkg.sv
// Shared definitions for the I2C bus observer.
// Token codes are visible at the top-level ports and must stay fixed.
package obs_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        TK_START  = 3'd0,
        TK_RSTART = 3'd1,
        TK_ADDR   = 3'd2,
        TK_DATA   = 3'd3,
        TK_ACK    = 3'd4,
        TK_NACK   = 3'd5,
        TK_STOP   = 3'd6
    } tok_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_RS, PH_BYTE, PH_ACK, PH_STOP
    } replay_ph_e;

    typedef struct packed {
        logic              rs;       // a repeated START preceded this byte
        logic              is_addr;  // first byte after a START
        logic              ack;      // 1 = acknowledged
        logic [BYTE_W-1:0] val;
    } cap_entry_t;
endpackage

// File: rtl/obs_line_filter.sv
// Two-flop synchronizer followed by a stability filter for one bus line.
// Assumes the line idles high; the output follows the synchronized input
// only after it has held a new value for FILT_LEN consecutive clocks.
module obs_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    localparam int FCW = $clog2(FILT_LEN + 1);

    logic           sync1, sync2;
    logic [FCW-1:0] run_cnt;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= line_in;
            sync2 <= sync1;
        end
    end

    // Accept a new level only once it has been stable long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_out <= 1'b1;
            run_cnt  <= '0;
        end else if (sync2 == line_out) begin
            run_cnt <= '0;
        end else if (run_cnt == FCW'(FILT_LEN - 1)) begin
            line_out <= sync2;
            run_cnt  <= '0;
        end else begin
            run_cnt <= run_cnt + FCW'(1);
        end
    end
endmodule

// File: rtl/obs_bit_engine.sv
// Bus condition detector and byte assembler.
// Inputs are the filtered SCL/SDA levels. Emits single-cycle events for
// START (with repeated flag), STOP and each completed byte plus its ninth bit.
// Bits are sampled on the SCL rising edge, MSB first; ignored while idle.
module obs_bit_engine
    import obs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              scl_f,
    input  logic              sda_f,
    output logic              ev_start,
    output logic              ev_rep,
    output logic              ev_stop,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              byte_ack,
    output logic              byte_addr,
    output logic              busy
);
    logic              scl_q, sda_q;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              addr_next;
    logic              start_c, stop_c, rise_c;

    // Classify the line transitions seen this cycle.
    always_comb begin
        start_c = scl_f & scl_q & sda_q & ~sda_f;
        stop_c  = scl_f & scl_q & ~sda_q & sda_f;
        rise_c  = scl_f & ~scl_q;
    end

    // Track bus state and shift in bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            ev_start  <= 1'b0;
            ev_rep    <= 1'b0;
            ev_stop   <= 1'b0;
            byte_done <= 1'b0;
            byte_val  <= '0;
            byte_ack  <= 1'b0;
            byte_addr <= 1'b0;
            busy      <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            addr_next <= 1'b0;
        end else begin
            scl_q     <= scl_f;
            sda_q     <= sda_f;
            ev_start  <= 1'b0;
            ev_rep    <= 1'b0;
            ev_stop   <= 1'b0;
            byte_done <= 1'b0;
            if (abort) begin
                busy      <= 1'b0;
                bit_cnt   <= '0;
                addr_next <= 1'b0;
            end else if (start_c) begin
                ev_start  <= 1'b1;
                ev_rep    <= busy;
                busy      <= 1'b1;
                bit_cnt   <= '0;
                addr_next <= 1'b1;
            end else if (stop_c) begin
                ev_stop <= busy;
                busy    <= 1'b0;
                bit_cnt <= '0;
            end else if (rise_c && busy) begin
                if (bit_cnt == 4'(BYTE_W)) begin
                    byte_done <= 1'b1;
                    byte_val  <= shreg;
                    byte_ack  <= ~sda_f;
                    byte_addr <= addr_next;
                    addr_next <= 1'b0;
                    bit_cnt   <= '0;
                end else begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_f};
                    bit_cnt <= bit_cnt + 4'd1;
                end
            end
        end
    end
endmodule

// File: rtl/obs_ms_timer.sv
// Free-running millisecond counter: a prescaler divides the system clock
// by CLK_PER_MS and the count advances once per division. Wraps silently.
module obs_ms_timer #(
    parameter int CLK_PER_MS = 125000,
    parameter int TS_W       = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ms_now
);
    localparam int PW = $clog2(CLK_PER_MS);

    logic [PW-1:0] pre;

    // Divide the clock and advance the millisecond count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre    <= '0;
            ms_now <= '0;
        end else if (pre == PW'(CLK_PER_MS - 1)) begin
            pre    <= '0;
            ms_now <= ms_now + TS_W'(1);
        end else begin
            pre <= pre + PW'(1);
        end
    end
endmodule

// File: rtl/obs_capture.sv
// Transaction store, address filter and token replay.
// Bytes of the open transaction are written to a DEPTH-entry store. At
// STOP the transaction is kept or dropped; a kept one is replayed as one
// token per cycle, ending with a STOP token carrying the latched stamp.
// Assumes replay (about 2*DEPTH+3 cycles) ends before the next byte lands.
module obs_capture
    import obs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              ev_start,
    input  logic              ev_rep,
    input  logic              ev_stop,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              byte_ack,
    input  logic              byte_addr,
    input  logic              flt_en,
    input  logic [6:0]        flt_addr,
    input  logic [TS_W-1:0]   ms_now,
    output logic              tok_valid,
    output tok_kind_e         tok_kind,
    output logic [BYTE_W-1:0] tok_byte,
    output logic [TS_W-1:0]   tok_stamp,
    output logic              ovf
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    cap_entry_t      store [DEPTH];
    logic            in_tx, pend_rs, addr_known, keep_q;
    logic [CW-1:0]   cnt, rp_cnt;
    logic [IW-1:0]   rp_idx;
    logic [TS_W-1:0] stamp_q;
    replay_ph_e      phase;
    cap_entry_t      rd_e, nx_e;
    logic            wr_en, last_e;

    // Select the entry being replayed and its successor.
    always_comb begin
        rd_e   = store[rp_idx];
        nx_e   = store[rp_idx + IW'(1)];
        last_e = (CW'(rp_idx) + CW'(1)) == rp_cnt;
        wr_en  = byte_done && in_tx && !abort && (cnt != CW'(DEPTH));
    end

    // Write completed bytes into the store.
    always_ff @(posedge clk) begin
        if (wr_en)
            store[cnt[IW-1:0]] <= '{rs: pend_rs, is_addr: byte_addr,
                                    ack: byte_ack, val: byte_val};
    end

    // Capture bookkeeping, keep decision and replay sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_tx      <= 1'b0;
            pend_rs    <= 1'b0;
            addr_known <= 1'b0;
            keep_q     <= 1'b0;
            cnt        <= '0;
            rp_cnt     <= '0;
            rp_idx     <= '0;
            stamp_q    <= '0;
            phase      <= PH_IDLE;
            ovf        <= 1'b0;
            tok_valid  <= 1'b0;
            tok_kind   <= TK_START;
            tok_byte   <= '0;
            tok_stamp  <= '0;
        end else begin
            tok_valid <= 1'b0;
            tok_byte  <= '0;
            tok_stamp <= '0;
            if (abort) begin
                in_tx      <= 1'b0;
                pend_rs    <= 1'b0;
                addr_known <= 1'b0;
                cnt        <= '0;
                ovf        <= 1'b0;
                phase      <= PH_IDLE;
            end else begin
                unique case (phase)
                    PH_START: begin
                        tok_valid <= 1'b1;
                        tok_kind  <= TK_START;
                        phase     <= (rp_cnt == '0) ? PH_STOP : PH_BYTE;
                    end
                    PH_RS: begin
                        tok_valid <= 1'b1;
                        tok_kind  <= TK_RSTART;
                        phase     <= PH_BYTE;
                    end
                    PH_BYTE: begin
                        tok_valid <= 1'b1;
                        tok_kind  <= rd_e.is_addr ? TK_ADDR : TK_DATA;
                        tok_byte  <= rd_e.val;
                        phase     <= PH_ACK;
                    end
                    PH_ACK: begin
                        tok_valid <= 1'b1;
                        tok_kind  <= rd_e.ack ? TK_ACK : TK_NACK;
                        if (last_e) begin
                            phase <= PH_STOP;
                        end else begin
                            rp_idx <= rp_idx + IW'(1);
                            phase  <= nx_e.rs ? PH_RS : PH_BYTE;
                        end
                    end
                    PH_STOP: begin
                        tok_valid <= 1'b1;
                        tok_kind  <= TK_STOP;
                        tok_stamp <= stamp_q;
                        phase     <= PH_IDLE;
                    end
                    default: ;
                endcase

                if (ev_start) begin
                    if (ev_rep) begin
                        pend_rs <= 1'b1;
                    end else begin
                        in_tx      <= 1'b1;
                        cnt        <= '0;
                        ovf        <= 1'b0;
                        pend_rs    <= 1'b0;
                        addr_known <= 1'b0;
                        keep_q     <= 1'b0;
                    end
                end else if (byte_done && in_tx) begin
                    if (cnt == CW'(DEPTH)) begin
                        ovf <= 1'b1;
                    end else begin
                        cnt     <= cnt + CW'(1);
                        pend_rs <= 1'b0;
                    end
                    if (byte_addr && !addr_known) begin
                        addr_known <= 1'b1;
                        keep_q     <= (byte_val[7:1] == flt_addr);
                    end
                end else if (ev_stop && in_tx) begin
                    in_tx <= 1'b0;
                    if (!ovf && (!flt_en || (addr_known && keep_q))) begin
                        phase   <= PH_START;
                        rp_idx  <= '0;
                        rp_cnt  <= cnt;
                        stamp_q <= ms_now;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_bus_observer.sv
// Top of the passive I2C observer. Never drives the bus: filters both
// lines, decodes conditions and bytes, and replays kept transactions as
// a token stream stamped with a millisecond count.
module i2c_bus_observer
    import obs_pkg::*;
#(
    parameter int CLK_PER_MS = 125000,
    parameter int FILT_LEN   = 4,
    parameter int PAGE_BYTES = 8,
    parameter int TS_W       = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            scl_in,
    input  logic            sda_in,
    input  logic            filt_en,
    input  logic [6:0]      filt_addr,
    output logic            tok_valid,
    output logic [2:0]      tok_kind,
    output logic [7:0]      tok_byte,
    output logic [TS_W-1:0] tok_stamp,
    output logic            bus_busy,
    output logic            cap_overflow
);
    localparam int DEPTH = 2 * PAGE_BYTES;

    logic [1:0]        raw_l, flt_l;
    logic              ev_start, ev_rep, ev_stop, byte_done, byte_ack, byte_addr;
    logic [BYTE_W-1:0] byte_val;
    logic [TS_W-1:0]   ms_now;
    tok_kind_e         kind_e;

    assign raw_l = {scl_in, sda_in};

    for (genvar gi = 0; gi < 2; gi++) begin : g_line
        obs_line_filter #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk(clk), .rst_n(rst_n), .line_in(raw_l[gi]), .line_out(flt_l[gi])
        );
    end

    obs_bit_engine u_eng (
        .clk(clk), .rst_n(rst_n), .abort(abort),
        .scl_f(flt_l[1]), .sda_f(flt_l[0]),
        .ev_start(ev_start), .ev_rep(ev_rep), .ev_stop(ev_stop),
        .byte_done(byte_done), .byte_val(byte_val), .byte_ack(byte_ack),
        .byte_addr(byte_addr), .busy(bus_busy)
    );

    obs_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .TS_W(TS_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .ms_now(ms_now)
    );

    obs_capture #(.DEPTH(DEPTH), .TS_W(TS_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .abort(abort),
        .ev_start(ev_start), .ev_rep(ev_rep), .ev_stop(ev_stop),
        .byte_done(byte_done), .byte_val(byte_val), .byte_ack(byte_ack),
        .byte_addr(byte_addr), .flt_en(filt_en), .flt_addr(filt_addr),
        .ms_now(ms_now), .tok_valid(tok_valid), .tok_kind(kind_e),
        .tok_byte(tok_byte), .tok_stamp(tok_stamp), .ovf(cap_overflow)
    );

    assign tok_kind = kind_e;
endmodule

// File: rtl/obs_observer_chk.sv
// Protocol checker for the observer's outputs, bound to the top module.
// Tracks whether a token stream is open and the last STOP stamp.
module obs_observer_chk #(
    parameter int TS_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            abort,
    input logic            tok_valid,
    input logic [2:0]      tok_kind,
    input logic [TS_W-1:0] tok_stamp,
    input logic            bus_busy,
    input logic            cap_overflow
);
    logic            in_stream;
    logic [TS_W-1:0] last_stamp;
    logic            is_byte_tok, is_ack_tok;

    assign is_byte_tok = tok_valid && (tok_kind == 3'd2 || tok_kind == 3'd3);
    assign is_ack_tok  = tok_valid && (tok_kind == 3'd4 || tok_kind == 3'd5);

    // Follow the emitted stream boundaries and stamps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_stream  <= 1'b0;
            last_stamp <= '0;
        end else if (abort) begin
            in_stream <= 1'b0;
        end else if (tok_valid && tok_kind == 3'd0) begin
            in_stream <= 1'b1;
        end else if (tok_valid && tok_kind == 3'd6) begin
            in_stream  <= 1'b0;
            last_stamp <= tok_stamp;
        end
    end

    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == 3'd0) |-> !in_stream);                 // R4
    AST_INSIDE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind != 3'd0) |-> in_stream);                  // R4
    AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_byte_tok && !abort) |=> is_ack_tok);                         // R3
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |-> tok_kind <= 3'd6);                                 // R3
    AST_STAMP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == 3'd6) |-> tok_stamp >= last_stamp);    // R9
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!bus_busy && !tok_valid));                            // R11
    AST_OVF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cap_overflow |-> !tok_valid);                                    // R10
endmodule

bind i2c_bus_observer obs_observer_chk #(.TS_W(TS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .abort(abort), .tok_valid(tok_valid),
    .tok_kind(tok_kind), .tok_stamp(tok_stamp), .bus_busy(bus_busy),
    .cap_overflow(cap_overflow)
);

// File: tb/i2c_bus_observer_bench.sv
// Directed bench: one task per scenario, each comparing the token stream
// against expectations built from the requirements.
module i2c_bus_observer_bench;
    localparam int P_MS = 500;
    localparam int H    = 20;
    localparam int K_START = 0, K_RS = 1, K_ADDR = 2, K_DATA = 3,
                   K_ACK = 4, K_NACK = 5, K_STOP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort = 1'b0;
    logic        scl = 1'b1, sda = 1'b1;
    logic        filt_en = 1'b0;
    logic [6:0]  filt_addr = 7'h00;
    logic        tok_valid;
    logic [2:0]  tok_kind;
    logic [7:0]  tok_byte;
    logic [31:0] tok_stamp;
    logic        bus_busy, cap_overflow;

    int checks = 0, fails = 0;
    int cyc = 0;
    int got_k[256], got_b[256], exp_k[256], exp_b[256];
    int n_got = 0, n_exp = 0;
    int got_stamp = 0, got_t = 0, t_stop = 0, prev_stamp = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2c_bus_observer #(.CLK_PER_MS(P_MS), .FILT_LEN(4), .PAGE_BYTES(8), .TS_W(32))
    u_i2c_bus_observer (
        .clk(clk), .rst_n(rst_n), .abort(abort), .scl_in(scl), .sda_in(sda),
        .filt_en(filt_en), .filt_addr(filt_addr), .tok_valid(tok_valid),
        .tok_kind(tok_kind), .tok_byte(tok_byte), .tok_stamp(tok_stamp),
        .bus_busy(bus_busy), .cap_overflow(cap_overflow)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Record every token away from the active edge.
    always @(negedge clk) begin
        if (tok_valid && n_got < 256) begin
            got_k[n_got] = int'(tok_kind);
            got_b[n_got] = int'(tok_byte);
            if (tok_kind == 3'd6) begin
                got_stamp = int'(tok_stamp);
                got_t     = cyc;
            end
            n_got++;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic hw();
        repeat (H) @(negedge clk);
    endtask

    task automatic clear_streams();
        n_got = 0;
        n_exp = 0;
    endtask

    task automatic ex(input int k, input int b);
        exp_k[n_exp] = k;
        exp_b[n_exp] = b;
        n_exp++;
    endtask

    task automatic ex_byte(input int k, input int b, input bit ack);
        ex(k, b);
        ex(ack ? K_ACK : K_NACK, 0);
    endtask

    task automatic bus_start(input bit rep);
        if (rep) begin
            sda = 1'b1; hw();
            scl = 1'b1; hw();
        end
        sda = 1'b0; hw();
        scl = 1'b0; hw();
    endtask

    task automatic bus_byte(input logic [7:0] b, input bit ack,
                            input int stretch, input bit glitch);
        for (int i = 7; i >= 0; i--) begin
            sda = b[i]; hw();
            if (i == 3) repeat (stretch) @(negedge clk);
            if (i == 5 && glitch) begin
                scl = 1'b1;
                repeat (2) @(negedge clk);
                scl = 1'b0;
                hw();
            end
            scl = 1'b1; hw();
            scl = 1'b0;
        end
        sda = ack ? 1'b0 : 1'b1; hw();
        scl = 1'b1; hw();
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        sda = 1'b0; hw();
        scl = 1'b1; hw();
        sda = 1'b1; t_stop = cyc; hw();
    endtask

    task automatic cmp_stream(input string rq);
        bit ok = (n_got == n_exp);
        int bad = -1;
        repeat (150) @(negedge clk);
        ok = (n_got == n_exp);
        chk(ok, rq, "token count", n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++)
            if (bad < 0 && (got_k[i] != exp_k[i] || got_b[i] != exp_b[i])) bad = i;
        if (bad >= 0)
            chk(1'b0, rq, $sformatf("token %0d kind*256+byte", bad),
                got_k[bad] * 256 + got_b[bad], exp_k[bad] * 256 + exp_b[bad]);
        else
            chk(1'b1, rq, "token contents", 0, 0);
    endtask

    task automatic t_reset();
        chk(tok_valid == 1'b0, "R1", "tok_valid after reset", int'(tok_valid), 0);
        chk(bus_busy == 1'b0, "R1", "bus_busy after reset", int'(bus_busy), 0);
        chk(cap_overflow == 1'b0, "R1", "cap_overflow after reset", int'(cap_overflow), 0);
    endtask

    task automatic t_write_nack();
        int lo, hi;
        clear_streams();
        filt_en = 1'b0;
        bus_start(1'b0);
        chk(bus_busy == 1'b1, "R2", "busy after START", int'(bus_busy), 1);
        bus_byte(8'hA0, 1'b1, 0, 1'b0); ex(K_START, 0); ex_byte(K_ADDR, 'hA0, 1'b1);
        bus_byte(8'h3C, 1'b1, 0, 1'b0); ex_byte(K_DATA, 'h3C, 1'b1);
        bus_byte(8'hC5, 1'b0, 0, 1'b0); ex_byte(K_DATA, 'hC5, 1'b0);
        bus_stop(); ex(K_STOP, 0);
        chk(bus_busy == 1'b0, "R2", "busy after STOP", int'(bus_busy), 0);
        cmp_stream("R3 R4");
        lo = t_stop / P_MS - 1;
        hi = got_t / P_MS + 1;
        chk(got_stamp >= lo && got_stamp <= hi, "R9", "stamp within window", got_stamp, lo);
        prev_stamp = got_stamp;
    endtask

    task automatic t_combined();
        clear_streams();
        filt_en = 1'b1; filt_addr = 7'h50;
        bus_start(1'b0); ex(K_START, 0);
        bus_byte(8'hA0, 1'b1, 0, 1'b0); ex_byte(K_ADDR, 'hA0, 1'b1);
        bus_byte(8'h12, 1'b1, 0, 1'b0); ex_byte(K_DATA, 'h12, 1'b1);
        bus_start(1'b1); ex(K_RS, 0);
        chk(bus_busy == 1'b1, "R5", "busy across repeated START", int'(bus_busy), 1);
        bus_byte(8'hA1, 1'b1, 0, 1'b0); ex_byte(K_ADDR, 'hA1, 1'b1);
        bus_byte(8'h99, 1'b1, 0, 1'b0); ex_byte(K_DATA, 'h99, 1'b1);
        bus_byte(8'h66, 1'b0, 0, 1'b0); ex_byte(K_DATA, 'h66, 1'b0);
        bus_stop(); ex(K_STOP, 0);
        cmp_stream("R5 R6");
    endtask

    task automatic t_filter_drop();
        clear_streams();
        filt_en = 1'b1; filt_addr = 7'h50;
        bus_start(1'b0);
        bus_byte(8'h44, 1'b1, 0, 1'b0);
        bus_byte(8'h5A, 1'b1, 0, 1'b0);
        bus_stop();
        cmp_stream("R7");
    endtask

    task automatic t_filter_off();
        clear_streams();
        filt_en = 1'b0; filt_addr = 7'h50;
        bus_start(1'b0); ex(K_START, 0);
        bus_byte(8'h45, 1'b0, 0, 1'b0); ex_byte(K_ADDR, 'h45, 1'b0);
        bus_stop(); ex(K_STOP, 0);
        cmp_stream("R8");
    endtask

    task automatic t_stamp_gap();
        clear_streams();
        filt_en = 1'b0;
        repeat (3 * P_MS) @(negedge clk);
        bus_start(1'b0); ex(K_START, 0);
        bus_byte(8'h10, 1'b1, 0, 1'b0); ex_byte(K_ADDR, 'h10, 1'b1);
        bus_stop(); ex(K_STOP, 0);
        cmp_stream("R9");
        chk(got_stamp >= prev_stamp + 3, "R9", "stamp advanced over idle gap",
            got_stamp, prev_stamp + 3);
    endtask

    task automatic t_overflow();
        clear_streams();
        filt_en = 1'b0;
        bus_start(1'b0);
        bus_byte(8'hA0, 1'b1, 0, 1'b0);
        for (int i = 0; i < 16; i++) bus_byte(8'(i + 1), 1'b1, 0, 1'b0);
        bus_stop();
        cmp_stream("R10 overflow");
        chk(cap_overflow == 1'b1, "R10", "overflow flag after 17 bytes", int'(cap_overflow), 1);
    endtask

    task automatic t_exact_fill();
        clear_streams();
        filt_en = 1'b0;
        bus_start(1'b0); ex(K_START, 0);
        chk(cap_overflow == 1'b0, "R10", "overflow cleared by START", int'(cap_overflow), 0);
        bus_byte(8'hA0, 1'b1, 0, 1'b0); ex_byte(K_ADDR, 'hA0, 1'b1);
        for (int i = 0; i < 15; i++) begin
            bus_byte(8'(8'h80 + i), 1'b1, 0, 1'b0);
            ex_byte(K_DATA, 'h80 + i, 1'b1);
        end
        bus_stop(); ex(K_STOP, 0);
        cmp_stream("R10 exact fill");
        chk(cap_overflow == 1'b0, "R10", "no overflow at exact fill", int'(cap_overflow), 0);
    endtask

    task automatic t_abort();
        clear_streams();
        filt_en = 1'b0;
        bus_start(1'b0);
        bus_byte(8'hA0, 1'b1, 0, 1'b0);
        sda = 1'b1; hw();
        scl = 1'b1; hw(); scl = 1'b0; hw();
        @(negedge clk) abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        chk(bus_busy == 1'b0, "R11", "busy after abort", int'(bus_busy), 0);
        bus_byte(8'h55, 1'b1, 0, 1'b0);
        bus_stop();
        cmp_stream("R11 discard");
        clear_streams();
        bus_start(1'b0); ex(K_START, 0);
        bus_byte(8'hB2, 1'b1, 0, 1'b0); ex_byte(K_ADDR, 'hB2, 1'b1);
        bus_stop(); ex(K_STOP, 0);
        cmp_stream("R11 recovery");
    endtask

    task automatic t_stretch_glitch();
        clear_streams();
        filt_en = 1'b0;
        bus_start(1'b0); ex(K_START, 0);
        bus_byte(8'hA0, 1'b1, 400, 1'b0); ex_byte(K_ADDR, 'hA0, 1'b1);
        bus_byte(8'hE7, 1'b1, 0, 1'b1);   ex_byte(K_DATA, 'hE7, 1'b1);
        bus_stop(); ex(K_STOP, 0);
        cmp_stream("R12 R13");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_nack();
        t_combined();
        t_filter_drop();
        t_filter_off();
        t_stamp_gap();
        t_overflow();
        t_exact_fill();
        t_abort();
        t_stretch_glitch();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule